// File: doc/BRIEF.md
# Paced Interrupt Aggregation Controller

This block gathers interrupt causes from several module slots and turns them into a paced stream of interrupt messages for a host link. Each slot has four causes. Two are active-low request pins. One is a software force bit. The last is an active-low power-fail pin. The three pins are synchronized and inverted, and a pin level counts only after it has been seen on two consecutive synchronized samples.

Each cause latches into a status bit. In edge mode the bit holds until software writes 1 to clear it. In level mode the bit tracks the cause. Each cause also has an enable bit that masks it. All enabled status bits of all slots are ORed into one combined request.

A small pacing machine turns the combined request into message requests: an assert when the request appears, a repeated assert each time the aggregation period runs out while the request is still active, and a deassert when the request goes away (virtual-wire mode only). After a deassert it waits for a programmable gap before it may assert again. A simple register bus holds status, control and global settings. Packet formatting is left to the consumer of the message request.

Top module: `irq_pacer`

## Requirements
- R1: The request and power-fail pins are active low. A low level is recognized only when it is present at two consecutive clock edges, so a low pulse of one cycle sets no status, and a pulse of two or more cycles does.
- R2: Slot `s` has its status register at address `2*s` and its control register at `2*s+1`. The status bits are: bit 0 for request pin 0, bit 1 for request pin 1, bit 2 for the force bit, and bit 3 for the power-fail pin. In `ext_req_n`, slot `s` uses pins `2*s` and `2*s+1`.
- R3: In edge mode (control bit `4+i` = 0) status bit `i` sets on a rising edge of its cause. It stays set after the cause goes away, until a write of 1 to that bit. Writing 0 leaves it unchanged.
- R4: In level mode (control bit `4+i` = 1) status bit `i` follows its cause one cycle later, and a write of 1 to that bit has no effect.
- R5: When a new edge and a write-1-to-clear hit the same edge-mode status bit in the same cycle, the bit ends up set.
- R6: Control bits [3:0] enable status bits [3:0]. A set status bit whose enable is 0 produces no message and does not raise `irq_asserted`.
- R7: The combined request is the OR of every enabled status bit of every slot. When it is active, the pacer is idle and no gap is pending, one assert message is issued (`msg_valid`=1, `msg_assert`=1) and `irq_asserted` goes high.
- R8: While the combined request stays active, a new assert message is issued every `AGG_BASE_CYCLES << code` cycles. Here `code` is global register bits [3:0].
- R9: In virtual-wire mode (global bit 4 = 0), a fall of the combined request, for example after status is cleared, issues one deassert message (`msg_assert`=0), and `irq_asserted` goes low.
- R10: In message-signalled mode (global bit 4 = 1), no deassert message is ever issued. `msg_msi` reflects global bit 4.
- R11: After a deassert, the next assert comes no sooner than `max(gap,2)*GAP_TICK_CYCLES + 1` cycles after it. Here `gap` is global bits [24:16]. With the request active throughout, the assert comes exactly then.
- R12: The global register is at address `2*NUM_SLOTS` and resets to 0x0002_0000: code 0, virtual-wire mode, gap 2. Control registers read back bits [8:0] as written, with bit 8 being the force bit. Status registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ext_req_n | input | 2*NUM_SLOTS | Active-low request pins, two per slot |
| pwr_fail_n | input | NUM_SLOTS | Active-low power-fail pins, one per slot |
| msg_valid | output | 1 | One-cycle message request |
| msg_assert | output | 1 | Message type when `msg_valid`: 1 assert, 0 deassert |
| msg_msi | output | 1 | Message mode: 1 message-signalled, 0 virtual wire |
| irq_asserted | output | 1 | Pacer holds the interrupt asserted |

## Verification
The sharpest collision is a fresh edge on a cause landing in the same cycle as the software clear of that status bit. The bench provokes it by turning the force bit on and issuing the clear on the very next bus cycle, so that edge detection and the clear meet at one clock edge. It then reads the status back and expects it to be set. A second collision drops and restores the combined request on adjacent cycles. The bench expects one deassert and then an assert exactly one gap later, timed from the logged cycle numbers of the messages.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

   localparam int SRC_PER_SLOT = 4;
   localparam int SRC_REQ0     = 0;
   localparam int SRC_REQ1     = 1;
   localparam int SRC_FORCE    = 2;
   localparam int SRC_PFAIL    = 3;
   localparam int REG_W        = 32;
   localparam int GAP_CFG_W    = 9;
   localparam int CODE_W       = 4;

   typedef enum logic {
      PACE_IDLE   = 1'b0,
      PACE_ACTIVE = 1'b1
   } pace_state_e;

   typedef struct packed {
      logic                    force_src;
      logic [SRC_PER_SLOT-1:0] lvl;
      logic [SRC_PER_SLOT-1:0] en;
   } slot_ctrl_t;

endpackage

// File: rtl/irq_pin_filter.sv
module irq_pin_filter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic active
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   hist_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("irq_pin_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         hist_q <= 1'b1;
         active <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
         hist_q <= sync_q[SYNC_STAGES-1];
         if (sync_q[SYNC_STAGES-1] == hist_q)
            active <= ~hist_q;
      end
   end

   assert_glitch_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (!$past(sync_q[SYNC_STAGES-1]) && !$past(sync_q[SYNC_STAGES-1], 2)));

   assert_glitch_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(sync_q[SYNC_STAGES-1]) && $past(sync_q[SYNC_STAGES-1], 2)));

endmodule

// File: rtl/irq_slot.sv
module irq_slot
   import irq_pacer_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              req_n,
   input  logic                    pfail_n,
   input  logic                    wr_status,
   input  logic                    wr_ctrl,
   input  logic [8:0]              wdata,
   output logic [SRC_PER_SLOT-1:0] status,
   output slot_ctrl_t              ctrl,
   output logic                    pending
);

   logic [SRC_PER_SLOT-1:0] src, src_q, rise, clr, status_d;
   logic [1:0]              req_act;
   logic                    pfail_act;

   generate
      for (genvar p = 0; p < 2; p++) begin : g_req
         irq_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (req_n[p]),
            .active(req_act[p])
         );
      end
   endgenerate

   irq_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_pfail (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (pfail_n),
      .active(pfail_act)
   );

   assign src[SRC_REQ0]  = req_act[0];
   assign src[SRC_REQ1]  = req_act[1];
   assign src[SRC_FORCE] = ctrl.force_src;
   assign src[SRC_PFAIL] = pfail_act;

   assign rise = src & ~src_q;
   assign clr  = wr_status ? wdata[SRC_PER_SLOT-1:0] : '0;

   always_comb begin
      for (int i = 0; i < SRC_PER_SLOT; i++)
         status_d[i] = ctrl.lvl[i] ? src[i] : ((status[i] & ~clr[i]) | rise[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         src_q  <= '0;
         status <= '0;
      end else begin
         if (wr_ctrl)
            ctrl <= slot_ctrl_t'(wdata);
         src_q  <= src;
         status <= status_d;
      end
   end

   assign pending = |(status & ctrl.en);

   generate
      for (genvar i = 0; i < SRC_PER_SLOT; i++) begin : g_chk
         assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl.lvl[i] && status[i] && !clr[i]) |=> status[i]);
         assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl.lvl[i] && rise[i]) |=> status[i]);
      end
   endgenerate

endmodule

// File: rtl/irq_pace_fsm.sv
module irq_pace_fsm
   import irq_pacer_pkg::*;
#(
   parameter int AGG_BASE_CYCLES = 3200,
   parameter int GAP_TICK_CYCLES = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 combined,
   input  logic                 msi_mode,
   input  logic [CODE_W-1:0]    agg_code,
   input  logic [GAP_CFG_W-1:0] gap_cfg,
   output logic                 msg_valid,
   output logic                 msg_assert,
   output logic                 line_active
);

   localparam int AGG_W = $clog2(AGG_BASE_CYCLES + 1) + (1 << CODE_W);
   localparam int GAP_W = GAP_CFG_W + $clog2(GAP_TICK_CYCLES + 1) + 1;

   generate
      if (AGG_BASE_CYCLES < 1 || GAP_TICK_CYCLES < 1) begin : g_bad_timing
         $error("irq_pace_fsm: timing parameters must be positive");
      end
   endgenerate

   pace_state_e          state;
   logic [AGG_W-1:0]     agg_cnt, agg_reload;
   logic [GAP_W-1:0]     gap_cnt, gap_load;
   logic [GAP_CFG_W-1:0] gap_eff;

   assign agg_reload = (AGG_W'(AGG_BASE_CYCLES) << agg_code) - AGG_W'(1);
   assign gap_eff    = (gap_cfg < GAP_CFG_W'(2)) ? GAP_CFG_W'(2) : gap_cfg;
   assign gap_load   = GAP_W'(gap_eff) * GAP_W'(GAP_TICK_CYCLES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PACE_IDLE;
         agg_cnt    <= '0;
         gap_cnt    <= '0;
         msg_valid  <= 1'b0;
         msg_assert <= 1'b0;
      end else begin
         msg_valid <= 1'b0;
         case (state)
            PACE_IDLE: begin
               if (gap_cnt != '0) begin
                  gap_cnt <= gap_cnt - GAP_W'(1);
               end else if (combined) begin
                  msg_valid  <= 1'b1;
                  msg_assert <= 1'b1;
                  agg_cnt    <= agg_reload;
                  state      <= PACE_ACTIVE;
               end
            end
            PACE_ACTIVE: begin
               if (!combined) begin
                  state   <= PACE_IDLE;
                  gap_cnt <= gap_load;
                  if (!msi_mode) begin
                     msg_valid  <= 1'b1;
                     msg_assert <= 1'b0;
                  end
               end else if (agg_cnt == '0) begin
                  msg_valid  <= 1'b1;
                  msg_assert <= 1'b1;
                  agg_cnt    <= agg_reload;
               end else begin
                  agg_cnt <= agg_cnt - AGG_W'(1);
               end
            end
            default: state <= PACE_IDLE;
         endcase
      end
   end

   assign line_active = (state == PACE_ACTIVE);

   assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PACE_IDLE && !combined) |=> !msg_valid);

   assert_msi_no_deassert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PACE_ACTIVE && msi_mode) |=> !(msg_valid && !msg_assert));

   assert_gap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PACE_IDLE && gap_cnt != '0) |=> !msg_valid);

endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
   import irq_pacer_pkg::*;
#(
   parameter int NUM_SLOTS       = 3,
   parameter int AGG_BASE_CYCLES = 3200,
   parameter int GAP_TICK_CYCLES = 7,
   parameter int SYNC_STAGES     = 2,
   parameter int ADDR_W          = $clog2(2 * NUM_SLOTS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic [2*NUM_SLOTS-1:0] ext_req_n,
   input  logic [NUM_SLOTS-1:0]   pwr_fail_n,
   output logic                   msg_valid,
   output logic                   msg_assert,
   output logic                   msg_msi,
   output logic                   irq_asserted
);

   localparam int GLOBAL_ADDR = 2 * NUM_SLOTS;

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 16) begin : g_bad_slots
         $error("irq_pacer: NUM_SLOTS out of range 1..16");
      end
      if (ADDR_W < $clog2(GLOBAL_ADDR + 1)) begin : g_bad_addr
         $error("irq_pacer: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [CODE_W-1:0]       agg_code;
   logic                    msi_mode;
   logic [GAP_CFG_W-1:0]    gap_cfg;
   logic [SRC_PER_SLOT-1:0] slot_status [NUM_SLOTS];
   slot_ctrl_t              slot_ctrl   [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]    slot_pending;
   logic                    wr_global;
   logic                    unused_wdata;

   assign unused_wdata = ^{reg_wdata[31:25], reg_wdata[15:9]};
   assign wr_global    = reg_we && (reg_addr == ADDR_W'(GLOBAL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         agg_code <= '0;
         msi_mode <= 1'b0;
         gap_cfg  <= GAP_CFG_W'(2);
      end else if (wr_global) begin
         agg_code <= reg_wdata[CODE_W-1:0];
         msi_mode <= reg_wdata[4];
         gap_cfg  <= reg_wdata[16 +: GAP_CFG_W];
      end
   end

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         irq_slot #(.SYNC_STAGES(SYNC_STAGES)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_n    (ext_req_n[2*s +: 2]),
            .pfail_n  (pwr_fail_n[s]),
            .wr_status(reg_we && (reg_addr == ADDR_W'(2*s))),
            .wr_ctrl  (reg_we && (reg_addr == ADDR_W'(2*s + 1))),
            .wdata    (reg_wdata[8:0]),
            .status   (slot_status[s]),
            .ctrl     (slot_ctrl[s]),
            .pending  (slot_pending[s])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(GLOBAL_ADDR))
         reg_rdata = {7'd0, gap_cfg, 11'd0, msi_mode, agg_code};
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (reg_addr == ADDR_W'(2*s))
            reg_rdata = {28'd0, slot_status[s]};
         if (reg_addr == ADDR_W'(2*s + 1))
            reg_rdata = {23'd0, slot_ctrl[s]};
      end
   end

   irq_pace_fsm #(
      .AGG_BASE_CYCLES(AGG_BASE_CYCLES),
      .GAP_TICK_CYCLES(GAP_TICK_CYCLES)
   ) u_pace (
      .clk        (clk),
      .rst_n      (rst_n),
      .combined   (|slot_pending),
      .msi_mode   (msi_mode),
      .agg_code   (agg_code),
      .gap_cfg    (gap_cfg),
      .msg_valid  (msg_valid),
      .msg_assert (msg_assert),
      .line_active(irq_asserted)
   );

   assign msg_msi = msi_mode;

   assert_assert_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_asserted && !(|slot_pending)) |=> !irq_asserted);

endmodule

// File: tb/irq_pacer_bench.sv
`timescale 1ns/1ps
module irq_pacer_bench;

   localparam int NS   = 3;
   localparam int BASE = 16;
   localparam int TICK = 2;
   localparam int AW   = 3;
   localparam int GLB  = 2 * NS;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_we = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [2*NS-1:0] ext_req_n = '1;
   logic [NS-1:0]   pwr_fail_n = '1;
   logic            msg_valid, msg_assert, msg_msi, irq_asserted;

   always #5 clk = ~clk;

   irq_pacer #(
      .NUM_SLOTS(NS), .AGG_BASE_CYCLES(BASE), .GAP_TICK_CYCLES(TICK),
      .SYNC_STAGES(2), .ADDR_W(AW)
   ) u_irq_pacer (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req_n(ext_req_n),
      .pwr_fail_n(pwr_fail_n), .msg_valid(msg_valid), .msg_assert(msg_assert),
      .msg_msi(msg_msi), .irq_asserted(irq_asserted)
   );

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   int m_cyc [256];
   bit m_as  [256];
   bit m_msi [256];
   int m_n = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && msg_valid && m_n < 256) begin
         m_cyc[m_n] = cyc;
         m_as[m_n]  = msg_assert;
         m_msi[m_n] = msg_msi;
         m_n++;
      end
   end

   function automatic int agg_period(input int code);
      return BASE << code;
   endfunction

   function automatic int gap_delay(input int cfg);
      return ((cfg < 2) ? 2 : cfg) * TICK + 1;
   endfunction

   function automatic logic [31:0] ctrl_word(input int en, input int lvl, input int frc);
      return 32'((en & 15) | ((lvl & 15) << 4) | ((frc & 1) << 8));
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_addr  = AW'(a);
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = AW'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_req(input int idx, input int len);
      ext_req_n[idx] = 1'b0;
      repeat (len) @(negedge clk);
      ext_req_n[idx] = 1'b1;
   endtask

   initial begin
      #1_000_000;
      fails++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int v, base;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      rd(GLB, v);  chk("R12 global reset", v, 32'h0002_0000);
      for (int s = 0; s < NS; s++) begin
         rd(2*s, v); chk("R12 status reset", v, 0);
      end
      chk("R12 irq reset", int'(irq_asserted), 0);
      chk("R12 no message at reset", m_n, 0);

      wr(GLB, 32'h0002_0006);

      // R2 R7 R9: request pin 0 of slot 0
      wr(1, ctrl_word(1, 0, 0));
      rd(1, v); chk("R12 control readback", v, 1);
      pulse_req(0, 3);
      idle(8);
      rd(0, v); chk("R2 req0 in bit0", v, 1);
      chk("R7 line asserted", int'(irq_asserted), 1);
      chk("R7 one message", m_n, 1);
      chk("R7 assert type", int'(m_as[0]), 1);
      wr(0, 32'h1);
      idle(4);
      rd(0, v); chk("R3 w1c clears", v, 0);
      chk("R9 deassert issued", m_n, 2);
      chk("R9 deassert type", int'(m_as[1]), 0);
      chk("R9 line low", int'(irq_asserted), 0);

      // R2 R6: power fail of slot 2, disabled
      pwr_fail_n[2] = 1'b0; idle(2); pwr_fail_n[2] = 1'b1;
      idle(8);
      rd(4, v); chk("R2 pfail in bit3", v, 8);
      chk("R6 masked no message", m_n, 2);

      // R1: glitch on slot 1 pin 1
      pulse_req(3, 1);
      idle(8);
      rd(2, v); chk("R1 one-cycle glitch ignored", v, 0);
      pulse_req(3, 2);
      idle(8);
      rd(2, v); chk("R1 two-cycle pulse seen in bit1", v, 2);
      chk("R6 still masked", int'(irq_asserted), 0);

      // R6 R7: enable, OR across slots
      wr(5, ctrl_word(8, 0, 0));
      idle(3);
      chk("R6 enable raises line", int'(irq_asserted), 1);
      chk("R7 assert count", m_n, 3);
      chk("R7 assert type", int'(m_as[2]), 1);
      wr(3, ctrl_word(2, 0, 0));
      wr(5, ctrl_word(0, 0, 0));
      idle(3);
      chk("R7 other slot keeps request", m_n, 3);
      chk("R7 line held", int'(irq_asserted), 1);
      wr(3, ctrl_word(0, 0, 0));
      idle(3);
      chk("R6 mask drops request", m_n, 4);
      chk("R9 deassert after mask", int'(m_as[3]), 0);
      wr(2, 32'h2);
      wr(4, 32'h8);
      idle(6);

      // R4: level mode on the force bit
      wr(1, ctrl_word(0, 4, 1));
      idle(2);
      rd(0, v); chk("R4 level follows on", v, 4);
      wr(0, 32'h4);
      idle(1);
      rd(0, v); chk("R4 w1c ignored in level", v, 4);
      wr(1, ctrl_word(0, 4, 0));
      idle(2);
      rd(0, v); chk("R4 level follows off", v, 0);

      // R3 R5: edge mode on the force bit
      wr(1, ctrl_word(0, 0, 1));
      idle(2);
      rd(0, v); chk("R3 edge latch", v, 4);
      wr(1, ctrl_word(0, 0, 0));
      idle(2);
      rd(0, v); chk("R3 holds after cause gone", v, 4);
      wr(0, 32'h0);
      idle(1);
      rd(0, v); chk("R3 write of 0 no effect", v, 4);
      wr(1, ctrl_word(0, 0, 1));
      wr(0, 32'h4);
      idle(1);
      rd(0, v); chk("R5 set wins over clear", v, 4);
      wr(0, 32'h4);
      idle(1);
      rd(0, v); chk("R3 clear without edge", v, 0);
      wr(1, ctrl_word(0, 0, 0));
      idle(4);

      // R8: reissue period, code 0 then code 2
      wr(GLB, 32'h0002_0000);
      base = m_n;
      wr(1, ctrl_word(4, 4, 1));
      idle(60);
      chk("R8 reissue count code0", (m_n - base >= 4) ? 1 : 0, 1);
      chk("R8 period code0 a", m_cyc[base+1] - m_cyc[base], agg_period(0));
      chk("R8 period code0 b", m_cyc[base+2] - m_cyc[base+1], agg_period(0));
      chk("R8 reissue is assert", int'(m_as[base+2]), 1);
      wr(1, ctrl_word(0, 4, 0));
      idle(10);
      wr(GLB, 32'h0002_0002);
      base = m_n;
      wr(1, ctrl_word(4, 4, 1));
      idle(140);
      chk("R8 reissue count code2", (m_n - base >= 3) ? 1 : 0, 1);
      chk("R8 period code2", m_cyc[base+2] - m_cyc[base+1], agg_period(2));
      wr(1, ctrl_word(0, 4, 0));
      idle(10);

      // R11: deassert gap, gap 5 then gap 0 (clamped to 2)
      wr(GLB, 32'h0005_0006);
      wr(1, ctrl_word(4, 4, 1));
      idle(4);
      base = m_n;
      wr(1, ctrl_word(4, 4, 0));
      wr(1, ctrl_word(4, 4, 1));
      idle(20);
      chk("R11 deassert first", int'(m_as[base]), 0);
      chk("R11 reassert", int'(m_as[base+1]), 1);
      chk("R11 gap 5", m_cyc[base+1] - m_cyc[base], gap_delay(5));
      wr(GLB, 32'h0000_0006);
      base = m_n;
      wr(1, ctrl_word(4, 4, 0));
      wr(1, ctrl_word(4, 4, 1));
      idle(20);
      chk("R11 gap clamped", m_cyc[base+1] - m_cyc[base], gap_delay(0));
      wr(1, ctrl_word(0, 4, 0));
      idle(10);

      // R10: message-signalled mode
      wr(GLB, 32'h0002_0016);
      rd(GLB, v); chk("R12 global readback", v, 32'h0002_0016);
      base = m_n;
      wr(1, ctrl_word(4, 4, 1));
      idle(4);
      chk("R10 assert issued", m_n - base, 1);
      chk("R10 msi flag", int'(m_msi[base]), 1);
      wr(1, ctrl_word(0, 4, 0));
      idle(10);
      chk("R10 no deassert", m_n - base, 1);
      chk("R10 line low", int'(irq_asserted), 0);
      wr(GLB, 32'h0002_0006);
      idle(4);

      // random: R1 R3 R6 R7
      for (int it = 0; it < 24; it++) begin
         int f [NS];
         int en [NS];
         int len [NS];
         int exp_st, any;
         any = 0;
         for (int s = 0; s < NS; s++) begin
            f[s]   = int'($urandom % 2);
            en[s]  = int'($urandom % 16);
            len[s] = int'($urandom % 4);
            wr(2*s + 1, ctrl_word(en[s], 0, f[s]));
         end
         for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < NS; s++)
               ext_req_n[2*s] = !(t < len[s]);
            @(negedge clk);
         end
         ext_req_n = '1;
         idle(8);
         for (int s = 0; s < NS; s++) begin
            exp_st = ((len[s] >= 2) ? 1 : 0) | (f[s] << 2);
            if ((exp_st & en[s]) != 0) any = 1;
            rd(2*s, v); chk("R1 R3 random status", v, exp_st);
         end
         chk("R6 R7 random line", int'(irq_asserted), any);
         for (int s = 0; s < NS; s++) wr(2*s + 1, 32'h0);
         for (int s = 0; s < NS; s++) wr(2*s, 32'hF);
         idle(8);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule